// File: doc/BRIEF.md
# Compare-Channel Watchdog Timer

This block turns one compare channel of a 16-bit free-running counter into a watchdog. The channel holds an 8-bit compare value and an 8-bit offset. Each time the low byte of the counter rolls over, the new counter high byte is compared with the compare value. While the watchdog is armed, a match raises a one-cycle reset request. Software refreshes the watchdog by writing any value to the compare register. That write reloads the compare value with the current counter high byte plus the offset, wrapping modulo 256.

The watchdog comes out of reset armed, so firmware must either disarm it or refresh it in time. While it is armed, the block holds several counter controls. The counter runs whatever the run bit says. The counter bytes cannot be written. The clock-source select and the idle-pause bit are frozen. The channel reports a fixed software-timer mode and ignores writes to its mode register. A lock bit keeps the watchdog armed until the next reset.

A small controller runs three states. OFF means disarmed. ARMED means armed and unlocked. LOCKED means armed and locked. The transitions are these:
- Reset enters ARMED.
- ARMED goes to OFF on a mode write with the enable bit at 0 (disarm).
- ARMED goes to LOCKED on a mode write with both enable and lock set (lock).
- OFF goes to ARMED on a mode write with enable 1 and lock 0 (arm), or to LOCKED if lock is also 1 (arm-and-lock).
- LOCKED leaves only on reset.

A mode write with lock 1 and enable 0 in OFF leaves the block in OFF.

Top module: `cmp_wdog`

Register addresses (`addr`):

| Addr | Register | Contents |
|------|----------|----------|
| 0 | mode | bit7 idle-pause, bit6 enable, bit5 lock, bits2:0 clock-source select |
| 1 | run | bit0 software run bit |
| 2 | counter low byte | |
| 3 | counter high byte | |
| 4 | offset | |
| 5 | compare | |
| 6 | channel mode | |

## Requirements
- R1: After reset the state is ARMED and the request output is low. The mode register reads 0x40, and the run, counter, offset and compare registers read 0. The channel mode register reads the software-timer code 0x48.
- R2: While armed, any write to address 5 loads the compare register with counter-high plus offset.
- R3: While armed, when the counter low byte steps from 0xFF to 0x00 and the new high byte equals the compare value, the request output is high for exactly the next clock cycle.
- R4: If software refreshes with a nonzero offset before the match, no request pulse occurs at that rollover.
- R5: While armed, the counter advances on every selected tick even when the software run bit is 0. The run register reads back the value software last wrote.
- R6: While armed, writes to addresses 2 and 3 leave the counter unchanged. While disarmed, they load the counter.
- R7: While armed, mode writes leave the clock-source select and idle-pause bits unchanged. While disarmed, they take the written value.
- R8: While armed, the channel mode register reads 0x48 and writes to it are ignored. While disarmed, it reads its stored value.
- R9: Once in LOCKED, a mode write with enable 0 does not disarm the watchdog, and the mode register keeps reading 0x60, until reset.
- R10: The disarm transition releases every lock at once and blocks the request output, even if the counter passes the compare value.
- R11: The counter advances only on a tick of the source picked by the 3-bit select. It does not advance when idle-pause is set and `cpu_idle` is high.
- R12: The reload sum wraps modulo 256. For example, a high byte of 0xFF plus an offset of 0x03 gives 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| src_tick | input | 8 | Count-enable tick per clock source |
| cpu_idle | input | 1 | Processor idle indication |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
Timing of results:
- Register writes take effect at the clock edge that samples `wr_en`. Reads are combinational, so the bench reads one half-cycle after a write completes.
- A counter step becomes visible after the edge that samples the tick.
- The request pulse is registered at the same edge as the rollover that caused it. It is visible in the half-cycle that follows and gone one cycle later.

How the checks keep to this timing:
- The bench drives every input on falling edges.
- The tick task returns on the falling edge right after the last counted edge, and pulse checks are made there.
- A falling-edge monitor counts pulses, so that quiet windows (R4, R10) can be checked as "no new pulse".

// File: rtl/cmp_wdog_pkg.sv
package cmp_wdog_pkg;
    typedef enum logic [2:0] {
        A_MODE = 3'd0,
        A_RUN  = 3'd1,
        A_CLO  = 3'd2,
        A_CHI  = 3'd3,
        A_OFS  = 3'd4,
        A_CMP  = 3'd5,
        A_CHM  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } wd_state_e;

    localparam int B_IDLE = 7;
    localparam int B_EN   = 6;
    localparam int B_LOCK = 5;
    localparam logic [7:0] SWT_MODE = 8'h48;
endpackage

// File: rtl/cmp_wdog_ctrl.sv
module cmp_wdog_ctrl
    import cmp_wdog_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             run_wr,
    input  logic             en_bit,
    input  logic             lock_bit,
    input  logic             idle_bit,
    input  logic [SEL_W-1:0] sel_bits,
    input  logic             run_bit,
    output logic             wd_en,
    output logic             locked,
    output logic             idle_ctl,
    output logic [SEL_W-1:0] clksel,
    output logic             run_sw
);
    wd_state_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (mode_wr && en_bit) nxt = lock_bit ? ST_LOCKED : ST_ARMED;
            end
            ST_ARMED: begin
                if (mode_wr) begin
                    if (!en_bit)       nxt = ST_OFF;
                    else if (lock_bit) nxt = ST_LOCKED;
                end
            end
            ST_LOCKED: nxt = ST_LOCKED;
            default:   nxt = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ARMED;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_ctl <= 1'b0;
            clksel   <= '0;
            run_sw   <= 1'b0;
        end else begin
            if (mode_wr && st == ST_OFF) begin
                idle_ctl <= idle_bit;
                clksel   <= sel_bits;
            end
            if (run_wr) run_sw <= run_bit;
        end
    end

    always_comb begin
        wd_en  = (st != ST_OFF);
        locked = (st == ST_LOCKED);
    end
endmodule

// File: rtl/cmp_wdog_counter.sv
module cmp_wdog_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_lo,
    output logic [DW-1:0] cnt_hi,
    output logic [DW-1:0] hi_next,
    output logic          lo_wrap
);
    always_comb begin
        lo_wrap = step && (cnt_lo == {DW{1'b1}});
        hi_next = cnt_hi + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt_lo <= wdata;
            if (ld_hi) cnt_hi <= wdata;
        end else if (step) begin
            cnt_lo <= cnt_lo + DW'(1);
            if (lo_wrap) cnt_hi <= hi_next;
        end
    end
endmodule

// File: rtl/cmp_wdog_chan.sv
module cmp_wdog_chan
    import cmp_wdog_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_en,
    input  logic          wr_ofs,
    input  logic          wr_cmp,
    input  logic          wr_mode,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt_hi,
    input  logic [DW-1:0] hi_next,
    input  logic          lo_wrap,
    output logic [DW-1:0] offset,
    output logic [DW-1:0] cmp_hi,
    output logic [DW-1:0] mode_rd,
    output logic          match
);
    logic [DW-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset <= '0;
            cmp_hi <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ofs) offset <= wdata;
            if (wr_cmp) cmp_hi <= wd_en ? DW'(cnt_hi + offset) : wdata;
            if (wr_mode && !wd_en) mode_q <= wdata;
        end
    end

    always_comb begin
        mode_rd = wd_en ? DW'(SWT_MODE) : mode_q;
        match   = wd_en && lo_wrap && (hi_next == cmp_hi);
    end
endmodule

// File: rtl/cmp_wdog.sv
module cmp_wdog
    import cmp_wdog_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SRC_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [SRC_N-1:0] src_tick,
    input  logic             cpu_idle,
    output logic             wdt_reset_req
);
    localparam int SEL_W = $clog2(SRC_N);

    logic             wd_en, locked, idle_ctl, run_sw, step, lo_wrap, match;
    logic [SEL_W-1:0] clksel;
    logic [DW-1:0]    cnt_lo, cnt_hi, hi_next, offset, cmp_hi, chm_rd;
    logic [2*DW-1:0]  cnt;

    assign cnt  = {cnt_hi, cnt_lo};
    assign step = (run_sw || wd_en) && src_tick[clksel] && !(idle_ctl && cpu_idle);

    cmp_wdog_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (wr_en && addr == A_MODE),
        .run_wr   (wr_en && addr == A_RUN),
        .en_bit   (wdata[B_EN]),
        .lock_bit (wdata[B_LOCK]),
        .idle_bit (wdata[B_IDLE]),
        .sel_bits (wdata[SEL_W-1:0]),
        .run_bit  (wdata[0]),
        .wd_en    (wd_en),
        .locked   (locked),
        .idle_ctl (idle_ctl),
        .clksel   (clksel),
        .run_sw   (run_sw)
    );

    cmp_wdog_counter #(.DW(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ld_lo   (wr_en && addr == A_CLO && !wd_en),
        .ld_hi   (wr_en && addr == A_CHI && !wd_en),
        .wdata   (wdata),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .hi_next (hi_next),
        .lo_wrap (lo_wrap)
    );

    cmp_wdog_chan #(.DW(DW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_en   (wd_en),
        .wr_ofs  (wr_en && addr == A_OFS),
        .wr_cmp  (wr_en && addr == A_CMP),
        .wr_mode (wr_en && addr == A_CHM),
        .wdata   (wdata),
        .cnt_hi  (cnt_hi),
        .hi_next (hi_next),
        .lo_wrap (lo_wrap),
        .offset  (offset),
        .cmp_hi  (cmp_hi),
        .mode_rd (chm_rd),
        .match   (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_reset_req <= 1'b0;
        else        wdt_reset_req <= match;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE: begin
                rdata[B_IDLE]      = idle_ctl;
                rdata[B_EN]        = wd_en;
                rdata[B_LOCK]      = locked;
                rdata[SEL_W-1:0]   = clksel;
            end
            A_RUN:   rdata[0] = run_sw;
            A_CLO:   rdata = cnt_lo;
            A_CHI:   rdata = cnt_hi;
            A_OFS:   rdata = offset;
            A_CMP:   rdata = cmp_hi;
            A_CHM:   rdata = chm_rd;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_wdog_chk.sv
module cmp_wdog_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic          wd_en,
    input logic          locked,
    input logic [2:0]    clksel,
    input logic [2*DW-1:0] cnt,
    input logic [DW-1:0] offset,
    input logic [DW-1:0] cmp_hi,
    input logic          wdt_reset_req
);
    // R3: request lasts a single cycle
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |=> !wdt_reset_req);

    // R3: request only right after a low-byte rollover
    assert_pulse_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> (cnt[DW-1:0] == '0));

    // R10: no request unless armed in the cycle that produced it
    assert_masked_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_req |-> $past(wd_en));

    // R9: lock held until reset
    assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && wd_en));

    // R6: while armed the counter only holds or steps by one
    assert_cnt_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R7: clock-source select frozen while armed
    assert_sel_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_en |=> $stable(clksel));

    // R2: refresh reloads high byte plus offset
    assert_refresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_en && wr_en && addr == 3'd5) |=> (cmp_hi == $past(DW'(cnt[2*DW-1:DW] + offset))));
endmodule

bind cmp_wdog cmp_wdog_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wd_en         (wd_en),
    .locked        (locked),
    .clksel        (clksel),
    .cnt           (cnt),
    .offset        (offset),
    .cmp_hi        (cmp_hi),
    .wdt_reset_req (wdt_reset_req)
);

// File: tb/cmp_wdog_test.sv
module cmp_wdog_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] src_tick = 8'd0;
    logic       cpu_idle = 1'b0;
    logic       wdt_reset_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_wdog uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .src_tick      (src_tick),
        .cpu_idle      (cpu_idle),
        .wdt_reset_req (wdt_reset_req)
    );

    always @(negedge clk) if (rst_n && wdt_reset_req) pulses++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n, input int sel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = 8'd1 << sel;
        end
        @(negedge clk);
        src_tick = 8'd0;
    endtask

    task automatic prep(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ofs);
        wr(3'd0, 8'h00);
        wr(3'd2, lo);
        wr(3'd3, hi);
        wr(3'd4, ofs);
        wr(3'd0, 8'h40);
        wr(3'd5, 8'hAA);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 req", {7'd0, wdt_reset_req}, 8'h00);
        rd(3'd0, v); chk("R1 mode", v, 8'h40);
        rd(3'd1, v); chk("R1 run", v, 8'h00);
        rd(3'd2, v); chk("R1 cnt", v, 8'h00);
        rd(3'd5, v); chk("R1 cmp", v, 8'h00);
        rd(3'd6, v); chk("R1 chmode", v, 8'h48);
    endtask

    task automatic t_refresh();
        logic [7:0] v;
        prep(8'h10, 8'h12, 8'h05);
        rd(3'd5, v); chk("R2 reload", v, 8'h17);
        prep(8'h00, 8'hFF, 8'h03);
        rd(3'd5, v); chk("R12 wrap", v, 8'h02);
    endtask

    task automatic t_expire();
        logic [7:0] v;
        prep(8'hF0, 8'h12, 8'h01);
        ticks(15, 0);
        chk("R3 early", {7'd0, wdt_reset_req}, 8'h00);
        rd(3'd2, v); chk("R3 lo", v, 8'hFF);
        ticks(1, 0);
        chk("R3 pulse", {7'd0, wdt_reset_req}, 8'h01);
        @(negedge clk);
        chk("R3 single", {7'd0, wdt_reset_req}, 8'h00);
    endtask

    task automatic t_kick();
        int p0;
        prep(8'hF0, 8'h12, 8'h01);
        ticks(10, 0);
        wr(3'd4, 8'h02);
        wr(3'd5, 8'h00);
        p0 = pulses;
        ticks(6, 0);
        ticks(200, 0);
        chk("R4 no pulse", 8'(pulses - p0), 8'h00);
    endtask

    task automatic t_forced();
        logic [7:0] v;
        prep(8'h20, 8'h30, 8'h40);
        wr(3'd1, 8'h00);
        ticks(4, 0);
        rd(3'd2, v); chk("R5 runs", v, 8'h24);
        rd(3'd1, v); chk("R5 run reads", v, 8'h00);
        wr(3'd2, 8'h99);
        rd(3'd2, v); chk("R6 lo ignored", v, 8'h24);
        wr(3'd3, 8'h55);
        rd(3'd3, v); chk("R6 hi ignored", v, 8'h30);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h99);
        rd(3'd2, v); chk("R6 lo when off", v, 8'h99);
    endtask

    task automatic t_frozen();
        logic [7:0] v;
        wr(3'd0, 8'h40);
        wr(3'd0, 8'hC5);
        rd(3'd0, v); chk("R7 frozen", v, 8'h40);
        wr(3'd6, 8'h11);
        rd(3'd6, v); chk("R8 forced", v, 8'h48);
        wr(3'd0, 8'h00);
        rd(3'd6, v); chk("R8 ignored", v, 8'h00);
        wr(3'd6, 8'h11);
        rd(3'd6, v); chk("R8 off write", v, 8'h11);
        wr(3'd0, 8'h85);
        rd(3'd0, v); chk("R7 off write", v, 8'h85);
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        ticks(5, 0);
        rd(3'd2, v); chk("R11 other src", v, 8'h00);
        ticks(5, 5);
        rd(3'd2, v); chk("R11 sel src", v, 8'h05);
        cpu_idle = 1'b1;
        ticks(3, 5);
        rd(3'd2, v); chk("R11 idle", v, 8'h05);
        cpu_idle = 1'b0;
    endtask

    task automatic t_disable();
        logic [7:0] v;
        int p0;
        prep(8'hF0, 8'h12, 8'h01);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h00);
        p0 = pulses;
        ticks(20, 0);
        chk("R10 masked", 8'(pulses - p0), 8'h00);
        rd(3'd3, v); chk("R10 passed", v, 8'h13);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        wr(3'd0, 8'h60);
        rd(3'd0, v); chk("R9 locked", v, 8'h60);
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk("R9 hold", v, 8'h60);
        do_reset();
        rd(3'd0, v); chk("R9 reset clears", v, 8'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_refresh();
        t_expire();
        t_kick();
        t_forced();
        t_frozen();
        t_disable();
        t_lock();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule